// File: doc/BRIEF.md
# Programmable LFSR Test Pattern Generator

This block produces pseudo-random test patterns on chip for at-speed self-test. A run is set up by a self-test signature with three parts: a starting value, a feedback tap mask and a pattern count. A start pulse loads the starting value into the state register and captures the mask and the count. After that, the state advances once in every cycle where enable is high. Each step computes the parity of the state ANDed with the mask, shifts the state right by one place and puts the parity bit into the most significant position.

Each step shows the new state on the pattern output together with a one-cycle valid strobe. When the requested number of steps has been made, the block raises done and holds it until the next accepted start. Because the taps are a run-time mask, one instance can produce any feedback polynomial of its width. Response compaction and instruction sequencing are handled outside this block.

Top module: `lfsr_pattern_gen`

## Requirements
- R1: A start pulse while busy is low is accepted. On the next cycle, pattern equals the seed, valid is low, done is low and busy is high when count is non-zero.
- R2: Each step sets pattern to {^(pattern & mask), pattern[W-1:1]}. The mask used is the value captured at the accepted start.
- R3: Valid is high for exactly one cycle after each step. A run makes exactly count steps. The seed is never qualified by valid.
- R4: With enable low during a run, pattern and the remaining step count hold and valid stays low.
- R5: Done rises in the same cycle as the valid of the final step. Busy falls in that cycle too. Done stays high until the next accepted start.
- R6: A count of zero sets done in the cycle after start. Busy stays low and no valid is produced.
- R7: A start pulse while busy is high has no effect on pattern, count, done or busy.
- R8: Seed_zero shows whether the seed of the last accepted start was all zero. A zero seed gives zero on every step.
- R9: With W=3, mask 3'b101 and seed 3'b011, the patterns are 101, 010, 001, 100, 110, 111, 011, for a period of 7.
- R10: After synchronous reset, pattern is zero and valid, busy, done and seed_zero are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse that begins a run |
| en | input | 1 | Step enable; low stalls the run |
| seed | input | W | Starting state, captured at start |
| mask | input | W | Feedback tap mask, captured at start |
| count | input | CW | Number of steps to make, captured at start |
| pattern | output | W | Current state, registered |
| valid | output | 1 | One-cycle strobe for each new pattern |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished; held until next start |
| seed_zero | output | 1 | Seed of the last accepted start was zero |

## Verification
Two functions can fall in the same cycle: a start request and the final step of a run. The bench raises start together with enable in the cycle that makes the last step. The block must treat that start as ignored, because busy is still high at that edge. Done must rise with the last valid, and pattern must keep the final state instead of reloading the seed. A second collision pairs a start with a stalled step. A cycle-accurate model in the bench judges every cycle against all outputs.

// File: rtl/lfsr_pg_pkg.sv
package lfsr_pg_pkg;
  // Widest state the shared feedback helper supports.
  localparam int MAXW = 64;

  // Parity of the state bits selected by the tap mask.
  function automatic logic masked_parity(logic [MAXW-1:0] st, logic [MAXW-1:0] taps);
    return ^(st & taps);
  endfunction
endpackage

// File: rtl/lfsr_state_reg.sv
module lfsr_state_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] seed_in,
  input  logic [W-1:0] mask_in,
  output logic [W-1:0] state
);
  localparam int MW = lfsr_pg_pkg::MAXW;

  logic [W-1:0] taps_q;
  logic         fb;

  assign fb = lfsr_pg_pkg::masked_parity(MW'(state), MW'(taps_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= '0;
      taps_q <= '0;
    end else if (load) begin
      state  <= seed_in;
      taps_q <= mask_in;
    end else if (step) begin
      state  <= {fb, state[W-1:1]};
    end
  end

  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(state));

  // R8
  zero_stays_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && step && state == '0) |=> (state == '0));
endmodule

// File: rtl/lfsr_run_ctrl.sv
module lfsr_run_ctrl #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          en,
  input  logic [CW-1:0] count,
  output logic          load,
  output logic          step,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] remaining;

  assign load = start && !busy;
  assign step = busy && en;

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else if (load) begin
      remaining <= count;
      busy      <= (count != '0);
      done      <= (count == '0);
    end else if (step) begin
      remaining <= remaining - CW'(1);
      if (remaining == CW'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  // R4
  stall_keeps_count_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !en) |=> ($stable(remaining) && busy));

  // R5
  busy_done_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R5
  done_held_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R6
  zero_count_done_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && count == '0) |=> (done && !busy));
endmodule

// File: rtl/lfsr_pattern_gen.sv
module lfsr_pattern_gen #(
  parameter int W  = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          en,
  input  logic [W-1:0]  seed,
  input  logic [W-1:0]  mask,
  input  logic [CW-1:0] count,
  output logic [W-1:0]  pattern,
  output logic          valid,
  output logic          busy,
  output logic          done,
  output logic          seed_zero
);
  logic load, step;

  lfsr_run_ctrl #(.CW(CW)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .en    (en),
    .count (count),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  lfsr_state_reg #(.W(W)) u_state (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .step    (step),
    .seed_in (seed),
    .mask_in (mask),
    .state   (pattern)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid     <= 1'b0;
      seed_zero <= 1'b0;
    end else begin
      valid <= step;
      if (load) seed_zero <= (seed == '0);
    end
  end

  // R3
  valid_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> $past(busy));

  // R7
  start_ignored_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && en) |=> valid);

  // R1
  seed_loaded_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (pattern == $past(seed) && !valid));

  // R8
  seed_zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (seed_zero == ($past(seed) == '0)));
endmodule

// File: tb/test_lfsr_pattern_gen.sv
`timescale 1ns/1ps
module test_lfsr_pattern_gen;
  localparam int W  = 3;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          en = 1'b0;
  logic [W-1:0]  seed = '0;
  logic [W-1:0]  mask = '0;
  logic [CW-1:0] count = '0;
  logic [W-1:0]  pattern;
  logic          valid, busy, done, seed_zero;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // Bench model state
  logic [W-1:0]  m_q = '0, m_mask = '0;
  logic [CW-1:0] m_rem = '0;
  logic          m_valid = 1'b0, m_busy = 1'b0, m_done = 1'b0, m_zero = 1'b0;

  always #2 clk = ~clk;

  lfsr_pattern_gen #(.W(W), .CW(CW)) i_lfsr_pattern_gen (
    .clk(clk), .rst(rst), .start(start), .en(en), .seed(seed), .mask(mask),
    .count(count), .pattern(pattern), .valid(valid), .busy(busy), .done(done),
    .seed_zero(seed_zero)
  );

  function automatic logic [W-1:0] next_state(logic [W-1:0] q, logic [W-1:0] m);
    return {^(q & m), q[W-1:1]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    logic acc, adv;
    acc = start && !m_busy;
    adv = m_busy && en;
    if (rst) begin
      m_q = '0; m_mask = '0; m_rem = '0;
      m_valid = 0; m_busy = 0; m_done = 0; m_zero = 0;
    end else if (acc) begin
      m_q = seed; m_mask = mask; m_rem = count;
      m_busy = (count != '0); m_done = (count == '0);
      m_zero = (seed == '0); m_valid = 0;
    end else if (adv) begin
      m_q = next_state(m_q, m_mask);
      m_valid = 1;
      m_rem = m_rem - CW'(1);
      if (m_rem == '0) begin m_busy = 0; m_done = 1; end
    end else begin
      m_valid = 0;
    end
  endtask

  // Drive at negedge, step the model at posedge, compare at next negedge.
  task automatic tick(logic st, logic e);
    start = st; en = e;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R2 pattern", 32'(pattern), 32'(m_q));
    chk("R3 valid", 32'(valid), 32'(m_valid));
    chk("R5 busy", 32'(busy), 32'(m_busy));
    chk("R5 done", 32'(done), 32'(m_done));
    chk("R8 seed_zero", 32'(seed_zero), 32'(m_zero));
  endtask

  task automatic setup(logic [W-1:0] s, logic [W-1:0] m, logic [CW-1:0] n);
    seed = s; mask = m; count = n;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] ref_seq [7];
    logic [W-1:0] got;
    int vi;
    void'($urandom(32'd1234));
    @(negedge clk);
    tick(0, 0);
    rst = 0;
    // R10 reset state
    chk("R10 pattern", 32'(pattern), 0);
    chk("R10 valid", 32'(valid), 0);
    chk("R10 busy", 32'(busy), 0);
    chk("R10 done", 32'(done), 0);
    chk("R10 seed_zero", 32'(seed_zero), 0);

    // R9 reference configuration, with R1 seed load
    ref_seq = '{3'b101, 3'b010, 3'b001, 3'b100, 3'b110, 3'b111, 3'b011};
    setup(3'b011, 3'b101, 8'd7);
    tick(1, 0);
    chk("R1 seed loaded", 32'(pattern), 32'h3);
    chk("R1 valid low", 32'(valid), 0);
    vi = 0;
    for (int i = 0; i < 7; i++) begin
      tick(0, 1);
      got = pattern;
      if (valid) begin
        chk("R9 sequence", 32'(got), 32'(ref_seq[vi]));
        vi++;
      end
    end
    chk("R3 valid count", vi, 7);
    chk("R5 done at end", 32'(done), 1);
    tick(0, 1);
    chk("R5 done held", 32'(done), 1);
    chk("R3 no extra valid", 32'(valid), 0);

    // R6 zero count
    setup(3'b110, 3'b011, 8'd0);
    tick(1, 1);
    chk("R6 done next cycle", 32'(done), 1);
    chk("R6 busy low", 32'(busy), 0);
    tick(0, 1);
    chk("R6 no valid", 32'(valid), 0);

    // R7 start while busy, plus collision with final step
    setup(3'b100, 3'b110, 8'd2);
    tick(1, 1);
    setup(3'b001, 3'b001, 8'd9);
    tick(1, 1);
    chk("R7 ignored mid-run", 32'(busy), 1);
    tick(1, 1);
    chk("R7 collision final step done", 32'(done), 1);
    tick(0, 0);
    chk("R7 no reload", 32'(pattern), 32'(next_state(next_state(3'b100, 3'b110), 3'b110)));

    // R4 stall and R7 start during stall
    setup(3'b101, 3'b111, 8'd3);
    tick(1, 0);
    tick(0, 0);
    tick(1, 0);
    chk("R4 stall holds seed", 32'(pattern), 32'h5);
    for (int i = 0; i < 3; i++) tick(0, 1);
    chk("R4 count kept", 32'(done), 1);

    // R8 zero seed
    setup(3'b000, 3'b111, 8'd4);
    tick(1, 1);
    chk("R8 flag set", 32'(seed_zero), 1);
    for (int i = 0; i < 4; i++) begin
      tick(0, 1);
      chk("R8 stays zero", 32'(pattern), 0);
    end

    // Random runs with random enable and stray start pulses
    for (int r = 0; r < 40; r++) begin
      setup(W'($urandom), W'($urandom), CW'($urandom_range(0, 12)));
      tick(1, 1'($urandom));
      for (int c = 0; c < 30; c++) begin
        if (($urandom % 8) == 0) seed = W'($urandom);
        tick(($urandom % 10) == 0, ($urandom % 4) != 0);
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule